// File: doc/BRIEF.md
# Segment Register Load Checker

This block judges whether loading a selector into one of the six segment registers is allowed. The caller supplies a strobe, a code for the destination register, and a few decoded facts about the selector: whether it is null, whether its descriptor describes a system object, and whether the segment is executable, readable or writable. A separate flag says whether the selector was fetched from a task-state segment while a task switch was in progress. Each destination register has its own set of type rules.

One clock after the strobe, the block presents a registered verdict. This is a fault flag and a two-bit class code, together with a one-cycle result-valid pulse. Privilege comparison, descriptor fetch, table-limit checks and not-present or stack classification belong to other logic. This block covers descriptor type legality only.

Top module: `seg_load_checker`

## Requirements
- R1: Target codes are CS=0, SS=1, DS=2, ES=3, FS=4 and GS=5. Codes 6 and 7 are reserved, and a strobe with a reserved code always yields class 1, whatever the attributes are.
- R2: `res_valid` is high in the cycle after each cycle in which `ld_valid` is high, and it is low after each cycle in which `ld_valid` is low.
- R3: The class encoding is 0 for no fault, 1 for general protection and 2 for invalid task segment. `res_fault` is high exactly when the reported class is non-zero.
- R4: A CS load gives class 1 when the selector is null. It also gives class 1 when the descriptor is a non-system, non-executable (data) segment. Any other CS load gives class 0.
- R5: An SS load gives class 1 when the selector is null, the descriptor is a system segment, or the segment is executable. These cases are checked in that order, ahead of R6.
- R6: A non-null SS load of a non-system, non-executable segment gives class 0 when the segment is writable. When the segment is not writable, it gives class 2 if `ld_from_task` is high and class 1 otherwise. `ld_from_task` has no effect on any other case.
- R7: A non-null load of DS, ES, FS or GS gives class 1 when the descriptor is a system segment. It also gives class 1 when the segment is executable and not readable. Readable code and data segments give class 0.
- R8: A null load of DS, ES, FS or GS gives class 0, and every descriptor attribute is ignored.
- R9: While `ld_valid` is low, `res_fault` and `res_class` keep their last values.
- R10: When `rst_n` is low, `res_valid`, `res_fault` and `res_class` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load request is present this cycle |
| ld_target | input | TGT_W | Destination register code |
| ld_null | input | 1 | Selector is null |
| ld_system | input | 1 | Descriptor describes a system object |
| ld_exec | input | 1 | Segment is executable |
| ld_read | input | 1 | Segment is readable |
| ld_write | input | 1 | Segment is writable |
| ld_from_task | input | 1 | Selector came from a task-state segment during a task switch |
| res_valid | output | 1 | Verdict valid pulse |
| res_fault | output | 1 | Load is illegal |
| res_class | output | 2 | Fault class code |

## Verification
The bench builds the block with the default three-bit target code. With that width the whole input space is reachable: all eight codes, including both reserved ones, crossed with all 64 combinations of the six attribute flags. Idle cycles are mixed into the sweep, with attributes changing while idle, so the hold behaviour is seen. The bench also applies a reset while a fault verdict is being shown, to confirm that reset clears it.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int unsigned TGT_CS = 0;
  localparam int unsigned TGT_SS = 1;
  localparam int unsigned TGT_DS = 2;
  localparam int unsigned TGT_GS = 5;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_GP   = 2'd1,
    CLS_TS   = 2'd2
  } fault_cls_e;

  typedef struct packed {
    logic is_null;
    logic is_system;
    logic is_exec;
    logic is_read;
    logic is_write;
    logic from_task;
  } sel_attr_t;
endpackage

// File: rtl/seg_rule_cell.sv
module seg_rule_cell
  import seg_chk_pkg::*;
#(
  parameter int unsigned CODE = 0
) (
  input  sel_attr_t  attr,
  output fault_cls_e cls
);
  generate
    if (CODE == TGT_CS) begin : g_code
      always_comb begin
        cls = CLS_NONE;
        if (attr.is_null) cls = CLS_GP;
        else if (!attr.is_system && !attr.is_exec) cls = CLS_GP;
      end
    end else if (CODE == TGT_SS) begin : g_stack
      always_comb begin
        cls = CLS_NONE;
        if (attr.is_null || attr.is_system || attr.is_exec) cls = CLS_GP;
        else if (!attr.is_write) cls = attr.from_task ? CLS_TS : CLS_GP;
      end
    end else if (CODE >= TGT_DS && CODE <= TGT_GS) begin : g_data
      always_comb begin
        cls = CLS_NONE;
        if (!attr.is_null) begin
          if (attr.is_system) cls = CLS_GP;
          else if (attr.is_exec && !attr.is_read) cls = CLS_GP;
        end
      end
    end else begin : g_resv
      assign cls = CLS_GP;
    end
  endgenerate
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
  import seg_chk_pkg::*;
#(
  parameter int unsigned TGT_W = 3
) (
  input  logic [TGT_W-1:0] target,
  input  sel_attr_t        attr,
  output fault_cls_e       cls
);
  localparam int unsigned NUM_TGT = 1 << TGT_W;

  fault_cls_e cls_by_tgt [NUM_TGT];

  generate
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_cell
      seg_rule_cell #(.CODE(g)) u_cell (
        .attr (attr),
        .cls  (cls_by_tgt[g])
      );
    end
  endgenerate

  assign cls = cls_by_tgt[target];
endmodule

// File: rtl/seg_result_reg.sv
module seg_result_reg
  import seg_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  fault_cls_e in_cls,
  output logic       out_valid,
  output logic       out_fault,
  output fault_cls_e out_cls
);
  logic       valid_d, fault_d, upd_en;
  fault_cls_e cls_d;

  always_comb begin
    upd_en  = in_valid;
    valid_d = in_valid;
    cls_d   = in_cls;
    fault_d = (in_cls != CLS_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_cls   <= CLS_NONE;
    end else begin
      out_valid <= valid_d;
      if (upd_en) begin
        out_fault <= fault_d;
        out_cls   <= cls_d;
      end
    end
  end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_chk_pkg::*;
#(
  parameter int unsigned TGT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [TGT_W-1:0] ld_target,
  input  logic             ld_null,
  input  logic             ld_system,
  input  logic             ld_exec,
  input  logic             ld_read,
  input  logic             ld_write,
  input  logic             ld_from_task,
  output logic             res_valid,
  output logic             res_fault,
  output logic [1:0]       res_class
);
  sel_attr_t  attr;
  fault_cls_e eval_cls, reg_cls;

  assign attr = '{is_null: ld_null, is_system: ld_system, is_exec: ld_exec,
                  is_read: ld_read, is_write: ld_write, from_task: ld_from_task};

  seg_rule_eval #(.TGT_W(TGT_W)) u_eval (
    .target (ld_target),
    .attr   (attr),
    .cls    (eval_cls)
  );

  seg_result_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (ld_valid),
    .in_cls    (eval_cls),
    .out_valid (res_valid),
    .out_fault (res_fault),
    .out_cls   (reg_cls)
  );

  assign res_class = reg_cls;
endmodule

// File: rtl/seg_load_checker_sva.sv
module seg_load_checker_sva #(
  parameter int unsigned TGT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic [TGT_W-1:0] ld_target,
  input logic             ld_null,
  input logic             ld_system,
  input logic             ld_exec,
  input logic             ld_read,
  input logic             ld_write,
  input logic             ld_from_task,
  input logic             res_valid,
  input logic             res_fault,
  input logic [1:0]       res_class
);
  localparam logic [TGT_W-1:0] C_CS = TGT_W'(0);
  localparam logic [TGT_W-1:0] C_SS = TGT_W'(1);
  localparam logic [TGT_W-1:0] C_DS = TGT_W'(2);
  localparam logic [TGT_W-1:0] C_GS = TGT_W'(5);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> res_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !res_valid);
  assert_fault_matches_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fault == (res_class != 2'd0)));
  assert_reserved_gp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_target > C_GS) |=> (res_class == 2'd1));
  assert_cs_null_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_target == C_CS && ld_null) |=> (res_class == 2'd1));
  assert_ss_null_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_target == C_SS && ld_null) |=> (res_class == 2'd1));
  assert_ts_only_ss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (ld_target != C_SS || !ld_from_task)) |=> (res_class != 2'd2));
  assert_data_null_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_target >= C_DS && ld_target <= C_GS && ld_null) |=> (res_class == 2'd0));
  assert_data_system_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_target >= C_DS && ld_target <= C_GS && !ld_null && ld_system)
      |=> (res_class == 2'd1));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> ($stable(res_class) && $stable(res_fault)));
endmodule

bind seg_load_checker seg_load_checker_sva #(.TGT_W(TGT_W)) u_sva (.*);

// File: tb/seg_load_checker_test.sv
`timescale 1ns/1ps
module seg_load_checker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_valid, ld_null, ld_system, ld_exec, ld_read, ld_write, ld_from_task;
  logic [2:0] ld_target;
  logic       res_valid, res_fault;
  logic [1:0] res_class;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    exp_cls = 0;
  bit    exp_valid = 0;
  string exp_tag = "R10";

  always #2.5 clk = ~clk;

  seg_load_checker uut (.*);

  // Behavioural reference for one load: class code and governing requirement
  function automatic int ref_cls(int t, bit [5:0] a, output string tag);
    bit nul = a[5], sys = a[4], ex = a[3], rd = a[2], wr = a[1], tsk = a[0];
    if (t > 5) begin tag = "R1"; return 1; end
    if (t == 0) begin tag = "R4"; return (nul || (!sys && !ex)) ? 1 : 0; end
    if (t == 1) begin
      if (nul || sys || ex) begin tag = "R5"; return 1; end
      tag = "R6";
      if (wr) return 0;
      return tsk ? 2 : 1;
    end
    if (nul) begin tag = "R8"; return 0; end
    tag = "R7";
    if (sys) return 1;
    if (ex && !rd) return 1;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string hold_tag);
    check("R2", int'(res_valid), int'(exp_valid), "res_valid");
    check(hold_tag, int'(res_class), exp_cls, "res_class");
    check("R3", int'(res_fault), (exp_cls != 0) ? 1 : 0, "res_fault");
  endtask

  task automatic drive(bit v, int t, bit [5:0] a);
    string tg;
    int    c;
    @(negedge clk);
    ld_valid = v;
    ld_target = 3'(t);
    {ld_null, ld_system, ld_exec, ld_read, ld_write, ld_from_task} = a;
    @(posedge clk);
    c = ref_cls(t, a, tg);
    exp_valid = v;
    if (v) begin exp_cls = c; exp_tag = tg; end
    #1;
    compare_all(v ? exp_tag : "R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ld_valid = 0; ld_target = 0;
    {ld_null, ld_system, ld_exec, ld_read, ld_write, ld_from_task} = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", int'(res_valid), 0, "reset res_valid");
    check("R10", int'(res_fault), 0, "reset res_fault");
    check("R10", int'(res_class), 0, "reset res_class");
    @(negedge clk);
    rst_n = 1'b1;

    for (int t = 0; t < 8; t++) begin
      for (int a = 0; a < 64; a++) begin
        drive(1'b1, t, 6'(a));
        if ((a % 7) == 3) drive(1'b0, 7 - t, 6'(63 - a));
      end
    end

    // Reset while a fault verdict is shown
    drive(1'b1, 6, 6'd0);
    check("R1", int'(res_class), 1, "reserved code before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", int'(res_valid), 0, "mid-run reset res_valid");
    check("R10", int'(res_fault), 0, "mid-run reset res_fault");
    check("R10", int'(res_class), 0, "mid-run reset res_class");
    @(negedge clk);
    rst_n = 1'b1;
    exp_valid = 0; exp_cls = 0;
    drive(1'b1, 1, 6'b000100);
    drive(1'b1, 1, 6'b000101);
    drive(1'b0, 0, 6'b100000);
    drive(1'b1, 3, 6'b111111);
    finish_run();
  end
endmodule